// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous SRAM Array

This block sits between a synchronous request port and an external asynchronous static RAM that is built from four byte-wide banks sharing one 19-bit address bus. Every bank has its own active-low select and active-low write strobe. A single active-low output enable serves all four banks. The controller turns each accepted request into one timed access. It holds every phase for a programmed number of clocks, so the write pulse, read access and bus turnaround meet the memory's minimum times at the chosen clock rate.

The same array can be presented to the user as 32, 16 or 8 bits wide. In the narrow widths the low user address bits choose which banks are selected. Write data is steered onto those banks, and the addressed bank data is moved down to the bottom of the read word. The user side is a valid/ready request plus a one-cycle read response pulse. The memory side has separate data-out, data-in and drive-enable signals that a pad ring would combine.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, every chip select, write strobe and the output enable are high (inactive), mem_dq_oe is 0 and rsp_valid is 0.
- R2: A write holds the chip select and write strobe of each selected lane low together for exactly WR_PULSE_CYC clocks. Unselected lanes stay high throughout.
- R3: mem_dq_oe is 1 in every cycle where a write strobe is low and in exactly one cycle after the strobes rise. Otherwise it is 0.
- R4: A read holds the selected chip selects and the output enable low, with all write strobes high, for RD_ACC_CYC clocks. The data is captured on the edge that ends that window and is shown with a one-cycle rsp_valid pulse.
- R5: When an access is the opposite direction of the previous one, TURN_CYC clocks with all strobes high and no drive come before it. Accesses in the same direction, and the first access after reset, have no such gap.
- R6: mem_dq_oe and an active output enable never occur in the same cycle.
- R7: Width code 0 (x32; code 3 acts the same) uses req_addr[18:0] as the memory address and req_be[i] to select lane i (bits 8i+7:8i). In read data, bytes of unselected lanes return 0.
- R8: Width code 1 (x16) uses req_addr[19:1] as the memory address. req_addr[0]=0 selects lanes 0-1 and req_addr[0]=1 selects lanes 2-3, under mask req_be[1:0]. req_wdata[15:0] is written to the chosen pair. A read returns the pair in rsp_rdata[15:0] with the upper half 0.
- R9: Width code 2 (x8) uses req_addr[20:2] as the memory address. req_addr[1:0] picks one lane, which is enabled by req_be[0]. req_wdata[7:0] is written to it. A read returns it in rsp_rdata[7:0] with the rest 0.
- R10: req_ready drops the cycle after a request is accepted. It returns once the access ends: after the hold cycle for writes, or together with rsp_valid for reads.
- R11: mem_addr does not change while any chip select stays low from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_mode | input | 2 | User word width: 0 x32, 1 x16, 2 x8, 3 as x32 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 21 | User word address (upper bits unused in wide modes) |
| req_wdata | input | 32 | Write data, low bits used in narrow modes |
| req_be | input | 4 | Byte/half enables |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 32 | Read data, right-aligned in narrow modes |
| mem_addr | output | 19 | Shared memory address |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned from memory |

## Verification
Counting from the edge that accepts a request, read data and rsp_valid appear RD_ACC_CYC clocks later, and req_ready returns WR_PULSE_CYC+1 clocks after a write is accepted. Both are pushed back by TURN_CYC clocks when the direction changes. The bench counts falling edges from acceptance and requires each result at exactly that count, so a gap that is too short or too long is caught. A lane model measures each strobe pulse at the falling edge on which it ends, keeps the bytes written, and drives read data only while the output enable is active. Every response is compared against a reference memory that the bench updates using the width mapping rules.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int HALF_W  = DATA_W / 2;
    localparam int PADDR_W = 19;
    localparam int SEL_W   = $clog2(LANES);
    localparam int UADDR_W = PADDR_W + SEL_W;

    typedef enum logic [1:0] {
        W32 = 2'd0,
        W16 = 2'd1,
        W8  = 2'd2
    } width_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TURN,
        S_WR,
        S_WHOLD,
        S_RD
    } phase_e;

    typedef struct packed {
        logic               wr;
        width_e             mode;
        logic [SEL_W-1:0]   sel;
        logic [PADDR_W-1:0] addr;
        logic [LANES-1:0]   lanes;
        logic [DATA_W-1:0]  wdata;
    } acc_t;

    function automatic width_e decode_width(input logic [1:0] code);
        case (code)
            2'd1:    return W16;
            2'd2:    return W8;
            default: return W32;
        endcase
    endfunction

    function automatic logic [PADDR_W-1:0] to_phys(input width_e m,
                                                   input logic [UADDR_W-1:0] ua);
        case (m)
            W16:     return ua[PADDR_W:1];
            W8:      return ua[PADDR_W+1:2];
            default: return ua[PADDR_W-1:0];
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] to_sel(input width_e m,
                                                input logic [UADDR_W-1:0] ua);
        case (m)
            W16:     return {{(SEL_W-1){1'b0}}, ua[0]};
            W8:      return ua[SEL_W-1:0];
            default: return '0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] to_lanes(input width_e m,
                                                  input logic [SEL_W-1:0] s,
                                                  input logic [LANES-1:0] be);
        logic [LANES-1:0] pair;
        pair = {{(LANES-2){1'b0}}, be[1:0]};
        case (m)
            W16:     return s[0] ? (pair << (LANES/2)) : pair;
            W8:      return {{(LANES-1){1'b0}}, be[0]} << s;
            default: return be;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] steer_wr(input width_e m,
                                                   input logic [DATA_W-1:0] wd);
        case (m)
            W16:     return {2{wd[HALF_W-1:0]}};
            W8:      return {LANES{wd[LANE_W-1:0]}};
            default: return wd;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input logic [LANES-1:0] ln);
        logic [DATA_W-1:0] mk;
        for (int i = 0; i < LANES; i++) begin
            mk[i*LANE_W +: LANE_W] = {LANE_W{ln[i]}};
        end
        return mk;
    endfunction

    function automatic logic [DATA_W-1:0] pick_rd(input width_e m,
                                                  input logic [SEL_W-1:0] s,
                                                  input logic [LANES-1:0] ln,
                                                  input logic [DATA_W-1:0] dq);
        logic [DATA_W-1:0] kept;
        kept = dq & byte_mask(ln);
        case (m)
            W16:     return s[0] ? {{HALF_W{1'b0}}, kept[DATA_W-1:HALF_W]}
                                 : {{HALF_W{1'b0}}, kept[HALF_W-1:0]};
            W8:      return {{(DATA_W-LANE_W){1'b0}}, kept[int'(s)*LANE_W +: LANE_W]};
            default: return kept;
        endcase
    endfunction

endpackage

// File: rtl/sram_req_map.sv
module sram_req_map
    import sram_lane_pkg::*;
(
    input  logic [1:0]         width_mode,
    input  logic               req_write,
    input  logic [UADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LANES-1:0]   req_be,
    output acc_t               cmd
);
    width_e           mode;
    logic [SEL_W-1:0] sel;

    always_comb begin
        mode      = decode_width(width_mode);
        sel       = to_sel(mode, req_addr);
        cmd.wr    = req_write;
        cmd.mode  = mode;
        cmd.sel   = sel;
        cmd.addr  = to_phys(mode, req_addr);
        cmd.lanes = to_lanes(mode, sel, req_be);
        cmd.wdata = steer_wr(mode, req_wdata);
    end
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
    import sram_lane_pkg::*;
#(
    parameter int WR_PULSE_CYC = 3,
    parameter int RD_ACC_CYC   = 2,
    parameter int TURN_CYC     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  acc_t             cmd_in,
    output logic             req_ready,
    output acc_t             cur,
    output logic [LANES-1:0] cs_n,
    output logic [LANES-1:0] we_n,
    output logic             oe_n,
    output logic             dq_oe,
    output logic             capture
);
    localparam int MAX_A = (WR_PULSE_CYC > RD_ACC_CYC) ? WR_PULSE_CYC : RD_ACC_CYC;
    localparam int MAX_C = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_ACC_CYC - 1);
    localparam logic [CNT_W-1:0] TN_LAST = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             have_dir;
    logic             last_wr;
    logic             need_turn;

    assign need_turn = (TURN_CYC > 0) && have_dir && (last_wr != cmd_in.wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= S_IDLE;
            cnt      <= '0;
            cur      <= '0;
            have_dir <= 1'b0;
            last_wr  <= 1'b0;
        end else begin
            case (phase)
                S_IDLE: begin
                    if (req_valid) begin
                        cur      <= cmd_in;
                        cnt      <= '0;
                        have_dir <= 1'b1;
                        last_wr  <= cmd_in.wr;
                        if (need_turn)      phase <= S_TURN;
                        else if (cmd_in.wr) phase <= S_WR;
                        else                phase <= S_RD;
                    end
                end
                S_TURN: begin
                    if (cnt == TN_LAST) begin
                        cnt   <= '0;
                        phase <= cur.wr ? S_WR : S_RD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                S_WR: begin
                    if (cnt == WR_LAST) begin
                        cnt   <= '0;
                        phase <= S_WHOLD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                S_WHOLD: phase <= S_IDLE;
                S_RD: begin
                    if (cnt == RD_LAST) begin
                        cnt   <= '0;
                        phase <= S_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_n      = '1;
        we_n      = '1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        req_ready = 1'b0;
        capture   = 1'b0;
        case (phase)
            S_IDLE:  req_ready = 1'b1;
            S_WR: begin
                cs_n  = ~cur.lanes;
                we_n  = ~cur.lanes;
                dq_oe = 1'b1;
            end
            S_WHOLD: dq_oe = 1'b1;
            S_RD: begin
                cs_n    = ~cur.lanes;
                oe_n    = 1'b0;
                capture = (cnt == RD_LAST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_rd_steer.sv
module sram_rd_steer
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  width_e            mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= pick_rd(mode, sel, lanes, dq_i);
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int WR_PULSE_CYC = 3,
    parameter int RD_ACC_CYC   = 2,
    parameter int TURN_CYC     = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         width_mode,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [UADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LANES-1:0]   req_be,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]   mem_cs_n,
    output logic [LANES-1:0]   mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_i
);
    acc_t cmd;
    acc_t cur;
    logic capture;

    sram_req_map u_map (
        .width_mode (width_mode),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .cmd        (cmd)
    );

    sram_cycle_fsm #(
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .RD_ACC_CYC   (RD_ACC_CYC),
        .TURN_CYC     (TURN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cmd_in    (cmd),
        .req_ready (req_ready),
        .cur       (cur),
        .cs_n      (mem_cs_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe),
        .capture   (capture)
    );

    sram_rd_steer u_rd (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .mode      (cur.mode),
        .sel       (cur.sel),
        .lanes     (cur.lanes),
        .dq_i      (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_addr = cur.addr;
    assign mem_dq_o = cur.wdata;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int WR_PULSE_CYC = 3
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  mem_cs_n,
    input logic [3:0]  mem_we_n,
    input logic        mem_oe_n,
    input logic        mem_dq_oe,
    input logic [18:0] mem_addr,
    input logic        rsp_valid
);
    localparam int PW = $clog2(WR_PULSE_CYC + 2) + 1;

    logic [PW-1:0] lo_cnt;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || (&mem_we_n)) lo_cnt <= '0;
        else                    lo_cnt <= lo_cnt + PW'(1);
        if (rst_q) begin
            a_r1_reset_quiet: assert ((&mem_cs_n) && (&mem_we_n) && mem_oe_n
                                      && !mem_dq_oe && !rsp_valid);
        end
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        ((&mem_we_n) && lo_cnt != '0) |-> (lo_cnt == PW'(WR_PULSE_CYC)));

    a_r2_we_in_cs: assert property (@(posedge clk) disable iff (rst)
        ((~mem_we_n) & mem_cs_n) == 4'b0000);

    a_r3_drive_hold: assert property (@(posedge clk) disable iff (rst)
        (!(&$past(mem_we_n)) && (&mem_we_n)) |-> mem_dq_oe);

    a_r4_read_no_we: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (&mem_we_n));

    a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.WR_PULSE_CYC(WR_PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WR_P = 3;
    localparam int RD_P = 2;
    localparam int TN_P = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  width_mode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic [3:0]  mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_i = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_ctrl #(.WR_PULSE_CYC(WR_P), .RD_ACC_CYC(RD_P), .TURN_CYC(TN_P)) uut (
        .clk(clk), .rst(rst), .width_mode(width_mode), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // ---------------- lane model ----------------
    logic [7:0] lmem [int];
    int  lo_cnt [4];
    logic [7:0] cap [4];
    int  contention = 0;
    int  addr_viol  = 0;
    logic [3:0]  prev_cs_n = 4'hF;
    logic [18:0] prev_addr = '0;

    function automatic logic [7:0] dflt(input int l, input logic [18:0] a);
        return 8'(int'(a) * 7 + l * 61 + 3);
    endfunction

    function automatic int key(input int l, input logic [18:0] a);
        return l * 524288 + int'(a);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int l = 0; l < 4; l++) lo_cnt[l] = 0;
            prev_cs_n = 4'hF;
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (!mem_cs_n[l] && !mem_we_n[l]) begin
                    lo_cnt[l]++;
                    cap[l] = mem_dq_o[l*8 +: 8];
                    chk($sformatf("R3 drive during strobe lane %0d", l), 32'(mem_dq_oe), 32'd1);
                end else if (lo_cnt[l] != 0) begin
                    chk($sformatf("R2 pulse width lane %0d", l), 32'(lo_cnt[l]), 32'(WR_P));
                    chk($sformatf("R3 drive hold lane %0d", l), 32'(mem_dq_oe), 32'd1);
                    lmem[key(l, mem_addr)] = cap[l];
                    lo_cnt[l] = 0;
                end
                if (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l])
                    mem_dq_i[l*8 +: 8] = lmem.exists(key(l, mem_addr)) ?
                                         lmem[key(l, mem_addr)] : dflt(l, mem_addr);
                else
                    mem_dq_i[l*8 +: 8] = 8'hA5;
            end
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!(&mem_cs_n) && !(&prev_cs_n) && mem_addr != prev_addr) addr_viol++;
            prev_cs_n = mem_cs_n;
            prev_addr = mem_addr;
        end
    end

    // ---------------- reference from requirements ----------------
    logic [7:0] refm [int];
    bit have_dir = 0;
    bit last_wr  = 0;

    function automatic logic [18:0] b_phys(input logic [1:0] md, input logic [20:0] ua);
        if (md == 2'd1) return ua[19:1];
        if (md == 2'd2) return ua[20:2];
        return ua[18:0];
    endfunction

    function automatic logic [3:0] b_lanes(input logic [1:0] md, input logic [20:0] ua,
                                           input logic [3:0] be);
        if (md == 2'd1) return ua[0] ? {be[1:0], 2'b00} : {2'b00, be[1:0]};
        if (md == 2'd2) return be[0] ? (4'b0001 << ua[1:0]) : 4'b0000;
        return be;
    endfunction

    function automatic logic [7:0] b_wbyte(input logic [1:0] md, input logic [31:0] wd, input int l);
        if (md == 2'd1) return wd[(l % 2) * 8 +: 8];
        if (md == 2'd2) return wd[7:0];
        return wd[l*8 +: 8];
    endfunction

    function automatic logic [7:0] ref_byte(input int l, input logic [18:0] a);
        return refm.exists(key(l, a)) ? refm[key(l, a)] : dflt(l, a);
    endfunction

    function automatic logic [31:0] b_expect(input logic [1:0] md, input logic [20:0] ua,
                                             input logic [3:0] be);
        logic [18:0] pa;
        logic [3:0]  ln;
        logic [31:0] w;
        pa = b_phys(md, ua);
        ln = b_lanes(md, ua, be);
        for (int l = 0; l < 4; l++) w[l*8 +: 8] = ln[l] ? ref_byte(l, pa) : 8'h00;
        if (md == 2'd1) return ua[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        if (md == 2'd2) return {24'h0, w[ua[1:0]*8 +: 8]};
        return w;
    endfunction

    task automatic do_req(input string tag, input logic wr, input logic [1:0] md,
                          input logic [20:0] ua, input logic [31:0] wd, input logic [3:0] be);
        int lat;
        int turn;
        logic [18:0] pa;
        logic [3:0]  ln;
        logic [31:0] exp_rd;
        turn = (have_dir && last_wr != wr) ? TN_P : 0;
        have_dir = 1;
        last_wr  = wr;
        @(negedge clk);
        width_mode = md; req_write = wr; req_addr = ua; req_wdata = wd; req_be = be;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        if (!wr) exp_rd = b_expect(md, ua, be);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 ready low after accept"}, 32'(req_ready), 32'd0);
        lat = 1;
        if (wr) begin
            while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
            chk({tag, " R10 write completion latency"}, 32'(lat), 32'(WR_P + 2 + turn));
            pa = b_phys(md, ua);
            ln = b_lanes(md, ua, be);
            for (int l = 0; l < 4; l++) if (ln[l]) refm[key(l, pa)] = b_wbyte(md, wd, l);
        end else begin
            while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
            chk({tag, " R4/R5 read latency"}, 32'(lat), 32'(RD_P + 1 + turn));
            chk({tag, " read data"}, rsp_rdata, exp_rd);
            chk({tag, " R10 ready with response"}, 32'(req_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cs idle in reset", 32'(mem_cs_n), 32'hF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 cs", 32'(mem_cs_n), 32'hF);
        chk("R1 we", 32'(mem_we_n), 32'hF);
        chk("R1 oe and drive", {30'd0, mem_oe_n, mem_dq_oe}, 32'd2);
        chk("R1 rsp", 32'(rsp_valid), 32'd0);

        // x32 full write, read back (turnaround R5)
        do_req("R7 x32 full write", 1'b1, 2'd0, 21'h00_0100, 32'hDEADBEEF, 4'hF);
        do_req("R7 x32 readback", 1'b0, 2'd0, 21'h00_0100, 32'h0, 4'hF);
        do_req("R5 same-direction read", 1'b0, 2'd0, 21'h00_0100, 32'h0, 4'hF);
        // masked write merge
        do_req("R2 x32 masked write", 1'b1, 2'd0, 21'h00_0100, 32'h11223344, 4'b0101);
        do_req("R7 merged read", 1'b0, 2'd0, 21'h00_0100, 32'h0, 4'hF);
        do_req("R7 masked read zeroes", 1'b0, 2'd0, 21'h00_0100, 32'h0, 4'b0011);
        do_req("R7 code3 as x32 read", 1'b0, 2'd3, 21'h00_0100, 32'h0, 4'b1100);
        do_req("R7 zero-mask write", 1'b1, 2'd0, 21'h00_0100, 32'hFFFFFFFF, 4'b0000);
        do_req("R7 after zero mask", 1'b0, 2'd0, 21'h00_0100, 32'h0, 4'hF);
        // x16 halves
        do_req("R8 x16 low half", 1'b1, 2'd1, {1'b0, 19'h0_0200, 1'b0}, 32'h0000_1111, 4'b0011);
        do_req("R8 x16 high half", 1'b1, 2'd1, {1'b0, 19'h0_0200, 1'b1}, 32'hABCD_2222, 4'b0011);
        do_req("R8 x32 view of halves", 1'b0, 2'd0, {2'b00, 19'h0_0200}, 32'h0, 4'hF);
        do_req("R8 x16 read high", 1'b0, 2'd1, {1'b0, 19'h0_0200, 1'b1}, 32'h0, 4'b0011);
        do_req("R8 x16 byte mask", 1'b1, 2'd1, {1'b0, 19'h0_0200, 1'b1}, 32'h0000_99FF, 4'b0010);
        do_req("R8 x16 masked readback", 1'b0, 2'd1, {1'b0, 19'h0_0200, 1'b1}, 32'h0, 4'b0011);
        // x8 lanes
        for (int s = 0; s < 4; s++)
            do_req("R9 x8 write", 1'b1, 2'd2, {19'h0_0300, 2'(s)}, 32'(8'h40 + s), 4'b0001);
        do_req("R9 x32 view of bytes", 1'b0, 2'd0, {2'b00, 19'h0_0300}, 32'h0, 4'hF);
        do_req("R9 x8 read lane2", 1'b0, 2'd2, {19'h0_0300, 2'd2}, 32'h0, 4'b0001);
        do_req("R9 x8 top address write", 1'b1, 2'd2, 21'h1F_FFFF, 32'h0000_007E, 4'b0001);
        do_req("R9 x8 top address read", 1'b0, 2'd2, 21'h1F_FFFF, 32'h0, 4'b0001);
        do_req("R9 x8 disabled read", 1'b0, 2'd2, 21'h1F_FFFF, 32'h0, 4'b0000);

        // constrained random mix
        for (int i = 0; i < 150; i++) begin
            logic [1:0]  md;
            logic [18:0] pa;
            logic [1:0]  sl;
            logic [20:0] ua;
            md = 2'($urandom % 3);
            pa = 19'h1_2300 + 19'($urandom % 8);
            sl = 2'($urandom);
            if (md == 2'd1)      ua = {1'b0, pa, sl[0]};
            else if (md == 2'd2) ua = {pa, sl};
            else                 ua = {2'b00, pa};
            do_req($sformatf("rand%0d", i), 1'($urandom), md, ua, $urandom, 4'($urandom));
        end

        repeat (4) @(negedge clk);
        chk("R6 no drive with output enable", 32'(contention), 32'd0);
        chk("R11 address stable under select", 32'(addr_viol), 32'd0);
        finish_run();
    end
endmodule